// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block rebuilds the negative, zero, overflow and carry flags of an integer operation long after the operation ran. It needs only three stored items: a class tag, the second operand and the result word. The first operand is never stored. Wherever a flag rule needs it, the block recovers it by inverse arithmetic on the result and the second operand. The evaluator is purely combinational. It covers nine operation classes: flag load, logic, add, subtract, byte compare, word compare, add-with-extend, subtract-with-extend and shift.

A small clocked wrapper performs multi-precision add and subtract using the same evaluator. It keeps a five-bit flag register, takes the carry-in from the extend bit of that register and updates the extend bit from its own rule. It also keeps zero sticky across a chain of words: an extended step can clear zero but can never set it. Software seeds the register through a direct write port before it starts a chain.

Top module: `lazy_flag_unit`

## Requirements
- R1: Flag word layout: C is bit 0, V is bit 1, Z is bit 2 and N is bit 3; the register also holds X in bit 4. For every class except flag load, Z is set when the evaluated result is zero, and N is set only when that result is non-zero and its top bit is one. Logic (tag 1) also clears V and C.
- R2: With tag 0 (flag load), `flags_o` equals `res_i[3:0]` and `src_i` has no effect.
- R3: With tag 2 (add), the first operand is rebuilt as a = res - src. C = (res < src), unsigned. V = top bit of (src ^ res) & ~(a ^ src).
- R4: With tag 3 (subtract), the minuend is rebuilt as m = res + src. C = (m < src), unsigned. V = top bit of (m ^ res) & (m ^ src).
- R5: Tags 4 and 5 apply the subtract rule to the low 8 bits and the low 16 bits respectively, for all four flags. Upper bits of both fields have no effect.
- R6: With tag 6 (add-with-extend), the operand is rebuilt as a = res - src - 1, C = (res <= src) unsigned, and V follows the add rule.
- R7: With tag 7 (subtract-with-extend), the minuend is rebuilt as m = res + src + 1, C = (m <= src) unsigned, and V follows the subtract rule.
- R8: With tag 8 (shift), N and Z follow the result, C is set when `src_i` is non-zero, and V is zero.
- R9: Tags 9 to 15 raise `tag_err_o` and drive `flags_o` to zero. Valid tags keep `tag_err_o` low.
- R10: An extended add (`ext_sub_i`=0) gives `ext_res_o` = op1 + op2 + X. At the next clock X becomes (res <= op2) when X was set and (res < op2) when it was clear, and C equals the new X.
- R11: An extended subtract gives `ext_res_o` = op1 - op2 - X. At the next clock X becomes (op1 <= op2) when X was set and (op1 < op2) when it was clear.
- R12: After an extended step, Z is the evaluated zero ANDed with the previous Z, so it is never newly set.
- R13: Reset clears `ccr_o` to zero. A direct write loads `ccr_wdata_i` at the next clock and wins over an extended step in the same cycle. With neither a write nor a step, the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tag_i | input | 4 | Operation class tag for the direct evaluator |
| src_i | input | 32 | Stored second operand, or carry-out for shift |
| res_i | input | 32 | Stored result word, or flag word for flag load |
| flags_o | output | 4 | Rebuilt {N,Z,V,C} |
| tag_err_o | output | 1 | Unrecognised tag |
| ext_valid_i | input | 1 | Perform one extended add or subtract step |
| ext_sub_i | input | 1 | 1 selects subtract, 0 selects add |
| op1_i | input | 32 | First operand of the extended step |
| op2_i | input | 32 | Second operand of the extended step |
| ccr_wr_i | input | 1 | Direct write of the flag register |
| ccr_wdata_i | input | 5 | Value for the direct write {X,N,Z,V,C} |
| ext_res_o | output | 32 | Combinational result of the extended step |
| ccr_o | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The evaluator has no state, so a wrong rebuilt operand or a wrong comparison shows up on `flags_o` in the same cycle as the stimulus. The vectors aim at sign-boundary and equality cases, where a swapped `<` and `<=` or a wrong extend term flips exactly one bit. In the wrapper, a bad extend bit or a bad sticky-zero rule surfaces on `ccr_o` one clock after the step. It also corrupts `ext_res_o` of the next step at once, because that step takes its carry-in from X. Chains are therefore checked step by step, with Z seeded both set and clear.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  typedef enum logic [3:0] {
    TAG_LOAD  = 4'd0,
    TAG_LOGIC = 4'd1,
    TAG_ADD   = 4'd2,
    TAG_SUB   = 4'd3,
    TAG_CMP8  = 4'd4,
    TAG_CMP16 = 4'd5,
    TAG_ADDX  = 4'd6,
    TAG_SUBX  = 4'd7,
    TAG_SHIFT = 4'd8
  } lfu_tag_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_X = 4;
  localparam int NZVC_W = 4;
  localparam int CCR_W  = 5;
endpackage

// File: rtl/lfu_arith_flags.sv
// Add/sub family flags at one width, first operand rebuilt from res and src.
module lfu_arith_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] res_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] opnd;
  logic [W-1:0] cin_w;

  assign cin_w = {{(W-1){1'b0}}, cin_i};
  assign z_o   = (res_i == '0);
  assign n_o   = !z_o && res_i[MSB];

  always_comb begin
    if (sub_i) begin
      opnd = res_i + src_i + cin_w;   // minuend
      c_o  = cin_i ? (opnd <= src_i) : (opnd < src_i);
      v_o  = (opnd[MSB] ^ res_i[MSB]) & (opnd[MSB] ^ src_i[MSB]);
    end else begin
      opnd = res_i - src_i - cin_w;   // augend
      c_o  = cin_i ? (res_i <= src_i) : (res_i < src_i);
      v_o  = (src_i[MSB] ^ res_i[MSB]) & ~(opnd[MSB] ^ src_i[MSB]);
    end
  end
endmodule

// File: rtl/lfu_flag_eval.sv
module lfu_flag_eval
  import lfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]        tag_i,
  input  logic [W-1:0]      src_i,
  input  logic [W-1:0]      res_i,
  output logic [NZVC_W-1:0] nzvc_o,
  output logic              bad_o
);
  localparam int LANES = 3;  // lane 0: byte, lane 1: word, lane 2: full

  logic [LANES-1:0] ln_n, ln_z, ln_v, ln_c;
  logic             full_sub, full_cin;

  assign full_sub = (tag_i == TAG_SUB) || (tag_i == TAG_SUBX);
  assign full_cin = (tag_i == TAG_ADDX) || (tag_i == TAG_SUBX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int CW = (g == 0) ? 8 : (g == 1) ? 16 : W;
    lfu_arith_flags #(.W(CW)) u_lane (
      .src_i (src_i[CW-1:0]),
      .res_i (res_i[CW-1:0]),
      .sub_i ((g == LANES-1) ? full_sub : 1'b1),
      .cin_i ((g == LANES-1) ? full_cin : 1'b0),
      .n_o   (ln_n[g]),
      .z_o   (ln_z[g]),
      .v_o   (ln_v[g]),
      .c_o   (ln_c[g])
    );
  end

  always_comb begin
    bad_o  = 1'b0;
    nzvc_o = '0;
    case (tag_i)
      TAG_LOAD:  nzvc_o = res_i[NZVC_W-1:0];
      TAG_LOGIC: nzvc_o = {ln_n[2], ln_z[2], 1'b0, 1'b0};
      TAG_ADD, TAG_SUB, TAG_ADDX, TAG_SUBX:
                 nzvc_o = {ln_n[2], ln_z[2], ln_v[2], ln_c[2]};
      TAG_CMP8:  nzvc_o = {ln_n[0], ln_z[0], ln_v[0], ln_c[0]};
      TAG_CMP16: nzvc_o = {ln_n[1], ln_z[1], ln_v[1], ln_c[1]};
      TAG_SHIFT: nzvc_o = {ln_n[2], ln_z[2], 1'b0, |src_i};
      default:   bad_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/lfu_ext_arith.sv
module lfu_ext_arith
  import lfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic [W-1:0]     op1_i,
  input  logic [W-1:0]     op2_i,
  input  logic             wr_i,
  input  logic [CCR_W-1:0] wdata_i,
  output logic [W-1:0]     res_o,
  output logic [CCR_W-1:0] ccr_o
);
  logic [CCR_W-1:0]  ccr_q, ccr_d;
  logic              x_in, x_new, z_new;
  logic [3:0]        ev_tag;
  logic [NZVC_W-1:0] ev_nzvc;
  logic              ev_bad;

  assign x_in  = ccr_q[FLAG_X];
  assign res_o = sub_i ? (op1_i - op2_i - {{(W-1){1'b0}}, x_in})
                       : (op1_i + op2_i + {{(W-1){1'b0}}, x_in});

  always_comb begin
    if (sub_i) begin
      ev_tag = x_in ? TAG_SUBX : TAG_SUB;
      x_new  = x_in ? (op1_i <= op2_i) : (op1_i < op2_i);
    end else begin
      ev_tag = x_in ? TAG_ADDX : TAG_ADD;
      x_new  = x_in ? (res_o <= op2_i) : (res_o < op2_i);
    end
  end

  lfu_flag_eval #(.W(W)) u_eval (
    .tag_i  (ev_tag),
    .src_i  (op2_i),
    .res_i  (res_o),
    .nzvc_o (ev_nzvc),
    .bad_o  (ev_bad)
  );

  // Z may only be cleared across a chain
  assign z_new = ev_nzvc[FLAG_Z] & ccr_q[FLAG_Z];

  always_comb begin
    ccr_d = ccr_q;
    if (wr_i)         ccr_d = wdata_i;
    else if (valid_i) ccr_d = {x_new, ev_nzvc[FLAG_N], z_new, ev_nzvc[FLAG_V], ev_nzvc[FLAG_C]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= '0;
    else         ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;

  AST_EXT_TAG_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !ev_bad);  // R10
  AST_X_TRACKS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wr_i) |=> (ccr_q[FLAG_X] == ccr_q[FLAG_C]));  // R11
  AST_Z_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wr_i && !ccr_q[FLAG_Z]) |=> !ccr_q[FLAG_Z]);  // R12
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ccr_q == $past(wdata_i)));  // R13
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !valid_i) |=> $stable(ccr_q));  // R13
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit
  import lfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       tag_i,
  input  logic [W-1:0]     src_i,
  input  logic [W-1:0]     res_i,
  output logic [3:0]       flags_o,
  output logic             tag_err_o,
  input  logic             ext_valid_i,
  input  logic             ext_sub_i,
  input  logic [W-1:0]     op1_i,
  input  logic [W-1:0]     op2_i,
  input  logic             ccr_wr_i,
  input  logic [CCR_W-1:0] ccr_wdata_i,
  output logic [W-1:0]     ext_res_o,
  output logic [CCR_W-1:0] ccr_o
);
  lfu_flag_eval #(.W(W)) u_eval (
    .tag_i  (tag_i),
    .src_i  (src_i),
    .res_i  (res_i),
    .nzvc_o (flags_o),
    .bad_o  (tag_err_o)
  );

  lfu_ext_arith #(.W(W)) u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ext_valid_i),
    .sub_i   (ext_sub_i),
    .op1_i   (op1_i),
    .op2_i   (op2_i),
    .wr_i    (ccr_wr_i),
    .wdata_i (ccr_wdata_i),
    .res_o   (ext_res_o),
    .ccr_o   (ccr_o)
  );

  AST_NZ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i != TAG_LOAD) |-> !(flags_o[FLAG_N] && flags_o[FLAG_Z]));  // R1
  AST_BAD_TAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o |-> (flags_o == '0));  // R9
  AST_BAD_TAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o == (tag_i > TAG_SHIFT));  // R9
  AST_SHIFT_NO_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i == TAG_SHIFT) |-> !flags_o[FLAG_V]);  // R8
  AST_LOAD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i == TAG_LOAD) |-> (flags_o == res_i[3:0]));  // R2
endmodule

// File: tb/lazy_flag_unit_tb.sv
module lazy_flag_unit_tb;
  localparam int NV = 25;
  // {tag, src, res, expected nzvc, expected err, req}
  localparam logic [76:0] VEC [NV] = '{
    {4'd1, 32'h0000_0000, 32'h0000_0000, 4'h4, 1'b0, 4'd1},  // R1
    {4'd1, 32'h0000_0000, 32'h8000_0000, 4'h8, 1'b0, 4'd1},  // R1
    {4'd1, 32'hFFFF_FFFF, 32'h0000_0001, 4'h0, 1'b0, 4'd1},  // R1
    {4'd0, 32'hFFFF_FFFF, 32'h0000_000B, 4'hB, 1'b0, 4'd2},  // R2
    {4'd0, 32'h0000_0000, 32'hFFFF_FFF6, 4'h6, 1'b0, 4'd2},  // R2
    {4'd2, 32'h0000_0001, 32'h0000_0000, 4'h5, 1'b0, 4'd3},  // R3
    {4'd2, 32'h0000_0001, 32'h8000_0000, 4'hA, 1'b0, 4'd3},  // R3
    {4'd2, 32'h0000_0003, 32'h0000_0005, 4'h0, 1'b0, 4'd3},  // R3
    {4'd3, 32'h0000_0005, 32'hFFFF_FFFE, 4'h9, 1'b0, 4'd4},  // R4
    {4'd3, 32'h0000_0001, 32'h7FFF_FFFF, 4'h2, 1'b0, 4'd4},  // R4
    {4'd3, 32'h0000_0005, 32'h0000_0000, 4'h4, 1'b0, 4'd4},  // R4
    {4'd4, 32'hABCD_EF20, 32'h1234_56F0, 4'h9, 1'b0, 4'd5},  // R5
    {4'd4, 32'h0000_0001, 32'hFFFF_FF7F, 4'h2, 1'b0, 4'd5},  // R5
    {4'd5, 32'h0000_1234, 32'hFFFF_0000, 4'h4, 1'b0, 4'd5},  // R5
    {4'd5, 32'h0001_0001, 32'h0000_7FFF, 4'h2, 1'b0, 4'd5},  // R5
    {4'd6, 32'h0000_0000, 32'h0000_0000, 4'h5, 1'b0, 4'd6},  // R6
    {4'd6, 32'h0000_0000, 32'h8000_0000, 4'hA, 1'b0, 4'd6},  // R6
    {4'd6, 32'h0000_0002, 32'h0000_0004, 4'h0, 1'b0, 4'd6},  // R6
    {4'd7, 32'h0000_0005, 32'hFFFF_FFFF, 4'h9, 1'b0, 4'd7},  // R7
    {4'd7, 32'h0000_0000, 32'h7FFF_FFFF, 4'h2, 1'b0, 4'd7},  // R7
    {4'd8, 32'h0000_0001, 32'h0000_0000, 4'h5, 1'b0, 4'd8},  // R8
    {4'd8, 32'h0000_0000, 32'h8000_0000, 4'h8, 1'b0, 4'd8},  // R8
    {4'd8, 32'h0000_0004, 32'h4000_0000, 4'h1, 1'b0, 4'd8},  // R8
    {4'd9, 32'h1234_5678, 32'h0000_0000, 4'h0, 1'b1, 4'd9},  // R9
    {4'd15,32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0, 1'b1, 4'd9}   // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tag_i = '0;
  logic [31:0] src_i = '0, res_i = '0;
  logic [3:0]  flags_o;
  logic        tag_err_o;
  logic        ext_valid_i = 1'b0, ext_sub_i = 1'b0;
  logic [31:0] op1_i = '0, op2_i = '0;
  logic        ccr_wr_i = 1'b0;
  logic [4:0]  ccr_wdata_i = '0;
  logic [31:0] ext_res_o;
  logic [4:0]  ccr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lazy_flag_unit u_dut (
    .clk_i, .rst_ni, .tag_i, .src_i, .res_i, .flags_o, .tag_err_o,
    .ext_valid_i, .ext_sub_i, .op1_i, .op2_i, .ccr_wr_i, .ccr_wdata_i,
    .ext_res_o, .ccr_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ccr_write(input logic [4:0] v);
    @(negedge clk_i);
    ccr_wr_i = 1'b1; ccr_wdata_i = v;
    @(posedge clk_i); #1;
    ccr_wr_i = 1'b0;
  endtask

  // drive one step, check comb result, then registered flags
  task automatic ext_step(input string req, input logic sub, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp_res,
                          input logic [4:0] exp_ccr);
    @(negedge clk_i);
    ext_valid_i = 1'b1; ext_sub_i = sub; op1_i = a; op2_i = b;
    #1 check(req, ext_res_o, exp_res);
    @(posedge clk_i); #1;
    ext_valid_i = 1'b0;
    check(req, {27'd0, ccr_o}, {27'd0, exp_ccr});
  endtask

  initial begin
    #1 check("R13", {27'd0, ccr_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R13", {27'd0, ccr_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      tag_i = VEC[i][76:73]; src_i = VEC[i][72:41]; res_i = VEC[i][40:9];
      #1;
      check($sformatf("R%0d vec%0d flags", VEC[i][3:0], i), {28'd0, flags_o}, {28'd0, VEC[i][8:5]});
      check($sformatf("R%0d vec%0d err", VEC[i][3:0], i), {31'd0, tag_err_o}, {31'd0, VEC[i][4]});
    end
    @(negedge clk_i);
    tag_i = 4'd0;

    // R10: add chain, X out of first word feeds the second
    ccr_write(5'h04);
    ext_step("R10", 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 5'h15);
    ext_step("R10", 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 5'h00);
    // R12: zero result cannot set a cleared Z
    ext_step("R12", 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 5'h00);
    // R11: subtract with X in
    ccr_write(5'h14);
    ext_step("R11", 1'b1, 32'h0000_0005, 32'h0000_0005, 32'hFFFF_FFFF, 5'h19);
    ext_step("R11", 1'b1, 32'h0000_0010, 32'h0000_000F, 32'h0000_0000, 5'h00);
    // R12: Z seeded set and result zero keeps Z
    ccr_write(5'h04);
    ext_step("R12", 1'b1, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 5'h04);
    ext_step("R11", 1'b1, 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFF, 5'h19);

    // R13: write wins over a step in the same cycle
    @(negedge clk_i);
    ext_valid_i = 1'b1; ext_sub_i = 1'b0; op1_i = 32'h1; op2_i = 32'h1;
    ccr_wr_i = 1'b1; ccr_wdata_i = 5'h0A;
    @(posedge clk_i); #1;
    ext_valid_i = 1'b0; ccr_wr_i = 1'b0;
    check("R13", {27'd0, ccr_o}, 32'h0A);
    // R13: operands without a step leave the register alone
    @(negedge clk_i);
    op1_i = 32'hFFFF_FFFF; op2_i = 32'h5; ext_sub_i = 1'b1; ccr_wdata_i = 5'h1F;
    repeat (2) @(posedge clk_i); #1;
    check("R13", {27'd0, ccr_o}, 32'h0A);

    // R13: async reset clears
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R13", {27'd0, ccr_o}, 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule